// File: doc/BRIEF.md
# Binary32 Floating-Point Adder

This block adds or subtracts two binary floating-point words. By default each word is 32 bits: a sign bit, then an 8-bit exponent with a bias of 127, then a 23-bit fraction. The block unpacks both operands and sorts each into one of five classes: zero, subnormal, normal, infinity or NaN. It places the operand with the larger magnitude first. It then shifts the other significand right to line the two up, keeping guard, round and sticky information. Next it adds or subtracts, normalizes with a leading-zero count, rounds once to nearest-even and packs the result. Special operands go through a separate path that overrides the arithmetic.

The exponent and fraction widths are parameters, so the same datapath also serves narrower formats. All arithmetic is combinational. A single register stage holds the packed result and the four flags. A result therefore appears at the outputs one clock after its operands are presented.

Top module: `fpadd_core`

## Requirements
- R1: A word with exponent field 0 and a nonzero fraction is read as 0.f·2^(1−bias), and a word with an exponent field from 1 to all-ones−1 is read as 1.f·2^(field−bias); the sign is the top bit and the fraction the low FRAC_W bits.
- R2: For finite operands, the result equals the exact sum rounded once to the nearest representable value; on an exact tie, the candidate with a zero fraction LSB is chosen.
- R3: A sum below the smallest normal magnitude is delivered as a subnormal (exponent field 0), never flushed to zero. Such sums are always exact, so flag_underflow (raised only when the pre-rounding result is tiny and inexact) stays clear for them.
- R4: If either operand is a NaN (exponent all ones, nonzero fraction), the result is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0 (0x7FC00000 by default). All flags are clear.
- R5: Infinity plus a finite value, or plus an infinity of the same effective sign, gives that infinity with all flags clear.
- R6: Two infinities of opposite effective sign give the canonical quiet NaN and raise flag_invalid.
- R7: If the rounded exponent reaches all ones, the result is an infinity of the result sign, with flag_overflow and flag_inexact set.
- R8: An exact zero sum of operands with opposite effective signs is +0. Two zeros of the same effective sign keep that sign.
- R9: With sub_en high, the result is op_a minus op_b, computed as op_a plus op_b with its sign bit inverted.
- R10: Outputs are registered. A result appears at the first rising edge after its operands, and a synchronous active-low reset clears sum_q and all flags to 0.
- R11: flag_inexact is set exactly when the delivered finite result differs from the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 1+EXP_W+FRAC_W | First operand |
| op_b | input | 1+EXP_W+FRAC_W | Second operand |
| sub_en | input | 1 | 1: subtract op_b from op_a; 0: add |
| sum_q | output | 1+EXP_W+FRAC_W | Registered packed result |
| flag_invalid | output | 1 | Infinity minus infinity |
| flag_overflow | output | 1 | Rounded result exceeded the finite range |
| flag_underflow | output | 1 | Tiny and inexact before rounding |
| flag_inexact | output | 1 | Delivered result differs from the exact sum |

## Verification
The main test sweeps every operand pair, for both add and subtract, on an instance with a 4-bit exponent and a 3-bit fraction. A reference computes each sum as an exact integer in units of the smallest subnormal and rounds it to nearest-even. This covers, in a single sweep, pairs that carry out, pairs that cancel heavily, pairs with wide exponent gaps (stressing the sticky bit), ties on both parities, subnormal and normal mixes, and every special operand class. Directed cases on the default binary32 instance separate the tie-to-even rule from a round-up rule. They also cover overflow from the largest finite value, the subnormal-to-normal transition, NaN canonicalization, the sign rules for zero results, and the one-cycle latency.

// File: rtl/fpadd_pkg.sv
// Shared types for the floating-point adder.
package fpadd_pkg;
    // Operand class after unpacking.
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } fp_class_e;
endpackage

// File: rtl/fpadd_unpack.sv
// Unpacks one floating-point word.
// Produces the sign, an effective exponent (1 for subnormals and zero), the
// significand with its hidden bit made explicit, and the operand class.
// Assumes the biased format: sign, EXP_W exponent bits, FRAC_W fraction bits.
module fpadd_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   word_i,
    output logic                    sign_o,
    output logic [EXP_W-1:0]        exp_o,
    output logic [FRAC_W:0]         sig_o,
    output fpadd_pkg::fp_class_e    cls_o
);
    import fpadd_pkg::*;

    logic [EXP_W-1:0]  exp_raw;
    logic [FRAC_W-1:0] frac_raw;
    logic              exp_zero;
    logic              exp_ones;

    assign sign_o   = word_i[EXP_W+FRAC_W];
    assign exp_raw  = word_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac_raw = word_i[FRAC_W-1:0];
    assign exp_zero = (exp_raw == '0);
    assign exp_ones = (exp_raw == '1);

    // Subnormals share the scale of the lowest normal exponent.
    always_comb begin
        exp_o = exp_zero ? EXP_W'(1) : exp_raw;
        sig_o = {~exp_zero, frac_raw};
    end

    // Sort the operand into its class.
    always_comb begin
        if (exp_zero)
            cls_o = (frac_raw == '0) ? CLS_ZERO : CLS_SUB;
        else if (exp_ones)
            cls_o = (frac_raw == '0) ? CLS_INF : CLS_NAN;
        else
            cls_o = CLS_NORM;
    end
endmodule

// File: rtl/fpadd_align.sv
// Orders the operands by magnitude and aligns the smaller one.
// The larger magnitude becomes the "big" operand. Its significand gains three
// zero bits (guard, round, sticky). The smaller significand is shifted right by
// the exponent gap, and every bit that falls off is ORed into its LSB.
// Assumes effective exponents, so magnitude order implies exponent order.
module fpadd_align #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    x_sign_i,
    input  logic [EXP_W-1:0]        x_exp_i,
    input  logic [FRAC_W:0]         x_sig_i,
    input  logic [EXP_W+FRAC_W-1:0] x_mag_i,
    input  logic                    y_sign_i,
    input  logic [EXP_W-1:0]        y_exp_i,
    input  logic [FRAC_W:0]         y_sig_i,
    input  logic [EXP_W+FRAC_W-1:0] y_mag_i,
    output logic                    big_sign_o,
    output logic [EXP_W-1:0]        big_exp_o,
    output logic [FRAC_W+3:0]       big_ext_o,
    output logic [FRAC_W+3:0]       small_al_o,
    output logic [EXP_W-1:0]        gap_o,
    output logic                    eff_sub_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int SH_W  = $clog2(EXT_W + 1);

    logic             swap;
    logic [EXP_W-1:0] small_exp;
    logic [SIG_W-1:0] small_sig;
    logic [SIG_W-1:0] big_sig;
    logic [SH_W-1:0]  sh;
    logic [EXT_W-1:0] small_ext;
    logic [EXT_W-1:0] shifted;
    logic [EXT_W-1:0] lost_mask;
    logic             sticky;

    // Pick the larger magnitude as the leading operand.
    always_comb begin
        swap       = (y_mag_i > x_mag_i);
        big_sign_o = swap ? y_sign_i : x_sign_i;
        big_exp_o  = swap ? y_exp_i  : x_exp_i;
        big_sig    = swap ? y_sig_i  : x_sig_i;
        small_exp  = swap ? x_exp_i  : y_exp_i;
        small_sig  = swap ? x_sig_i  : y_sig_i;
        eff_sub_o  = x_sign_i ^ y_sign_i;
        gap_o      = big_exp_o - small_exp;
    end

    // Shift the smaller significand right, clamping past the full width.
    always_comb begin
        if (int'(gap_o) > EXT_W)
            sh = SH_W'(EXT_W);
        else
            sh = SH_W'(gap_o);
        small_ext  = {small_sig, 3'b000};
        shifted    = small_ext >> sh;
        lost_mask  = ~({EXT_W{1'b1}} << sh);
        sticky     = |(small_ext & lost_mask);
        small_al_o = shifted | {{(EXT_W-1){1'b0}}, sticky};
        big_ext_o  = {big_sig, 3'b000};
    end
endmodule

// File: rtl/fpadd_lzc.sv
// Leading-zero counter. Returns W when the vector is all zeros.
module fpadd_lzc #(
    parameter int W = 27
) (
    input  logic [W-1:0]             vec_i,
    output logic [$clog2(W+1)-1:0]   count_o
);
    localparam int CW = $clog2(W + 1);

    // Scan from the MSB down and stop at the first set bit.
    always_comb begin
        logic found;
        found   = 1'b0;
        count_o = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec_i[i]) begin
                count_o = CW'(W - 1 - i);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpadd_normround.sv
// Adds or subtracts the aligned significands, normalizes, rounds and packs.
// The left shift after cancellation is capped so the exponent never drops
// below the subnormal scale, which yields subnormals directly. Rounding is to
// nearest with ties to even; a carry out of the significand bumps the exponent.
// Assumes big_ext_i holds the larger magnitude, so the difference is never negative.
module fpadd_normround #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    big_sign_i,
    input  logic [EXP_W-1:0]        big_exp_i,
    input  logic [FRAC_W+3:0]       big_ext_i,
    input  logic [FRAC_W+3:0]       small_al_i,
    input  logic                    eff_sub_i,
    output logic [EXP_W+FRAC_W:0]   word_o,
    output logic                    ovf_o,
    output logic                    unf_o,
    output logic                    inx_o
);
    localparam int SIG_W = FRAC_W + 1;
    localparam int EXT_W = SIG_W + 3;
    localparam int CW    = $clog2(EXT_W + 1);
    localparam int EW    = EXP_W + 2;
    localparam int MAXE  = (1 << EXP_W) - 1;

    logic [EXT_W:0]   sum;
    logic [CW-1:0]    lz;
    logic [EW-1:0]    lim;
    logic [EW-1:0]    sh;
    logic [EXT_W-1:0] norm;
    logic [EW-1:0]    e_n;
    logic [SIG_W-1:0] mant;
    logic             guard;
    logic             rest;
    logic             up;
    logic             inexact;
    logic             tiny;
    logic [SIG_W:0]   mant_r;
    logic             carry;
    logic             hidden;
    logic [EW-1:0]    e_r;
    logic [FRAC_W-1:0] frac;
    logic             zero;
    logic             overflow;

    // Magnitude add or subtract of the aligned significands.
    always_comb begin
        if (eff_sub_i)
            sum = {1'b0, big_ext_i} - {1'b0, small_al_i};
        else
            sum = {1'b0, big_ext_i} + {1'b0, small_al_i};
    end

    fpadd_lzc #(.W(EXT_W)) u_lzc (
        .vec_i   (sum[EXT_W-1:0]),
        .count_o (lz)
    );

    // Normalize: right by one on carry, else left by a capped zero count.
    always_comb begin
        lim = EW'(big_exp_i) - EW'(1);
        sh  = '0;
        if (sum[EXT_W]) begin
            norm = sum[EXT_W:1] | {{(EXT_W-1){1'b0}}, sum[0]};
            e_n  = EW'(big_exp_i) + EW'(1);
        end else begin
            sh   = (EW'(lz) > lim) ? lim : EW'(lz);
            norm = sum[EXT_W-1:0] << sh;
            e_n  = EW'(big_exp_i) - sh;
        end
    end

    // Round to nearest, ties to even, from guard and the sticky remainder.
    always_comb begin
        mant    = norm[EXT_W-1:3];
        guard   = norm[2];
        rest    = |norm[1:0];
        up      = guard & (rest | mant[0]);
        inexact = guard | rest;
        tiny    = ~norm[EXT_W-1];
        mant_r  = {1'b0, mant} + {{SIG_W{1'b0}}, up};
        carry   = mant_r[SIG_W];
        hidden  = carry | mant_r[FRAC_W];
        e_r     = e_n + {{(EW-1){1'b0}}, carry};
        frac    = carry ? '0 : mant_r[FRAC_W-1:0];
    end

    // Pack the result and derive the flags.
    always_comb begin
        zero     = (sum == '0);
        overflow = ~zero & hidden & (e_r >= EW'(MAXE));
        if (zero)
            word_o = {~eff_sub_i & big_sign_i, {(EXP_W+FRAC_W){1'b0}}};
        else if (overflow)
            word_o = {big_sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            word_o = {big_sign_i, hidden ? e_r[EXP_W-1:0] : {EXP_W{1'b0}}, frac};
        ovf_o = overflow;
        inx_o = ~zero & (inexact | overflow);
        unf_o = ~zero & tiny & inexact;
    end
endmodule

// File: rtl/fpadd_core.sv
// Floating-point adder/subtractor, top level.
// Unpacks both operands and applies sub_en to op_b's sign. It aligns, adds,
// normalizes and rounds in one combinational path. NaN and infinity operands
// override that result. The packed result and the flags are registered once.
// Assumes one operand pair per clock, with no handshake.
module fpadd_core #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic                  sub_en,
    output logic [EXP_W+FRAC_W:0] sum_q,
    output logic                  flag_invalid,
    output logic                  flag_overflow,
    output logic                  flag_underflow,
    output logic                  flag_inexact
);
    import fpadd_pkg::*;

    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] b_eff;
    logic              a_sign, b_sign;
    logic [EXP_W-1:0]  a_exp, b_exp;
    logic [FRAC_W:0]   a_sig, b_sig;
    fp_class_e         a_cls, b_cls;

    logic              big_sign;
    logic [EXP_W-1:0]  big_exp;
    logic [FRAC_W+3:0] big_ext;
    logic [FRAC_W+3:0] small_al;
    logic [EXP_W-1:0]  gap;
    logic              eff_sub;

    logic [WORD_W-1:0] arith_word;
    logic              arith_ovf, arith_unf, arith_inx;

    logic [WORD_W-1:0] res_d;
    logic              inv_d, ovf_d, unf_d, inx_d;

    assign b_eff = {op_b[WORD_W-1] ^ sub_en, op_b[MAG_W-1:0]};

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .word_i (op_a),
        .sign_o (a_sign),
        .exp_o  (a_exp),
        .sig_o  (a_sig),
        .cls_o  (a_cls)
    );

    fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .word_i (b_eff),
        .sign_o (b_sign),
        .exp_o  (b_exp),
        .sig_o  (b_sig),
        .cls_o  (b_cls)
    );

    fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
        .x_sign_i   (a_sign),
        .x_exp_i    (a_exp),
        .x_sig_i    (a_sig),
        .x_mag_i    (op_a[MAG_W-1:0]),
        .y_sign_i   (b_sign),
        .y_exp_i    (b_exp),
        .y_sig_i    (b_sig),
        .y_mag_i    (b_eff[MAG_W-1:0]),
        .big_sign_o (big_sign),
        .big_exp_o  (big_exp),
        .big_ext_o  (big_ext),
        .small_al_o (small_al),
        .gap_o      (gap),
        .eff_sub_o  (eff_sub)
    );

    fpadd_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_normround (
        .big_sign_i (big_sign),
        .big_exp_i  (big_exp),
        .big_ext_i  (big_ext),
        .small_al_i (small_al),
        .eff_sub_i  (eff_sub),
        .word_o     (arith_word),
        .ovf_o      (arith_ovf),
        .unf_o      (arith_unf),
        .inx_o      (arith_inx)
    );

    // Let NaN and infinity operands override the arithmetic path.
    always_comb begin
        res_d = arith_word;
        inv_d = 1'b0;
        ovf_d = arith_ovf;
        unf_d = arith_unf;
        inx_d = arith_inx;
        if (a_cls == CLS_NAN || b_cls == CLS_NAN) begin
            res_d = QNAN;
            {ovf_d, unf_d, inx_d} = 3'b000;
        end else if (a_cls == CLS_INF || b_cls == CLS_INF) begin
            {ovf_d, unf_d, inx_d} = 3'b000;
            if (a_cls == CLS_INF && b_cls == CLS_INF && a_sign != b_sign) begin
                res_d = QNAN;
                inv_d = 1'b1;
            end else if (a_cls == CLS_INF) begin
                res_d = {a_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else begin
                res_d = {b_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q          <= '0;
            flag_invalid   <= 1'b0;
            flag_overflow  <= 1'b0;
            flag_underflow <= 1'b0;
            flag_inexact   <= 1'b0;
        end else begin
            sum_q          <= res_d;
            flag_invalid   <= inv_d;
            flag_overflow  <= ovf_d;
            flag_underflow <= unf_d;
            flag_inexact   <= inx_d;
        end
    end

    // A NaN operand must give the canonical NaN with no invalid flag (R4).
    p_nan_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cls == CLS_NAN || b_cls == CLS_NAN) |=> (sum_q == QNAN && !flag_invalid));

    // Opposite infinities must give the canonical NaN and invalid (R6).
    p_inf_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cls == CLS_INF && b_cls == CLS_INF && a_sign != b_sign)
        |=> (sum_q == QNAN && flag_invalid));

    // Overflow delivers an infinity and is always inexact (R7).
    p_overflow_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_overflow |-> (sum_q[MAG_W-1:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                           && flag_inexact));

    // Exact cancellation of finite operands yields +0 (R8).
    p_cancel_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cls != CLS_NAN && a_cls != CLS_INF && b_cls != CLS_NAN && b_cls != CLS_INF
         && a_sign != b_sign && op_a[MAG_W-1:0] == b_eff[MAG_W-1:0])
        |=> (sum_q == '0));

    // With no exponent gap the aligned operand loses nothing (R2).
    p_align_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gap == '0) |-> (small_al[2:0] == 3'b000));

    // Underflow only comes with an inexact result at the bottom scale (R3).
    p_underflow_tiny_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_underflow |-> (flag_inexact && sum_q[MAG_W-1:FRAC_W] <= EXP_W'(1)));
endmodule

// File: tb/fpadd_core_tb.sv
// Bench: exhaustive sweep of a 4-bit-exponent, 3-bit-fraction instance against
// an exact integer reference, plus directed binary32 cases.
module fpadd_core_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    always #5 clk = ~clk;

    // Small format instance (1 + 4 + 3 bits).
    logic [7:0] s_a, s_b, s_sum;
    logic       s_sub, s_inv, s_ovf, s_unf, s_inx;

    // Binary32 instance.
    logic [31:0] w_a, w_b, w_sum;
    logic        w_sub, w_inv, w_ovf, w_unf, w_inx;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    fpadd_core #(.EXP_W(4), .FRAC_W(3)) u_dut (
        .clk (clk), .rst_n (rst_n), .op_a (s_a), .op_b (s_b), .sub_en (s_sub),
        .sum_q (s_sum), .flag_invalid (s_inv), .flag_overflow (s_ovf),
        .flag_underflow (s_unf), .flag_inexact (s_inx)
    );

    fpadd_core u_dut_sp (
        .clk (clk), .rst_n (rst_n), .op_a (w_a), .op_b (w_b), .sub_en (w_sub),
        .sum_q (w_sum), .flag_invalid (w_inv), .flag_overflow (w_ovf),
        .flag_underflow (w_unf), .flag_inexact (w_inx)
    );

    // Exact reference: {result, invalid, overflow, underflow, inexact}.
    function automatic logic [11:0] ref_small(logic [7:0] a, logic [7:0] b, logic sub);
        logic sa, sb, rs, up, inx;
        int ea, fa, eb, fb, ma, mb, s, m, k, q, rem, half, e;
        sa = a[7]; sb = b[7] ^ sub;
        ea = int'(a[6:3]); fa = int'(a[2:0]);
        eb = int'(b[6:3]); fb = int'(b[2:0]);
        if ((ea == 15 && fa != 0) || (eb == 15 && fb != 0)) return {8'h7C, 4'b0000};
        if (ea == 15 && eb == 15)
            return (sa != sb) ? {8'h7C, 4'b1000} : {sa, 7'h78, 4'b0000};
        if (ea == 15) return {sa, 7'h78, 4'b0000};
        if (eb == 15) return {sb, 7'h78, 4'b0000};
        ma = (ea == 0) ? fa : (8 + fa) << (ea - 1);
        mb = (eb == 0) ? fb : (8 + fb) << (eb - 1);
        s = (sa ? -ma : ma) + (sb ? -mb : mb);
        if (s == 0) begin
            rs = (sa == sb) ? sa : 1'b0;
            return {rs, 7'h00, 4'b0000};
        end
        rs = (s < 0);
        m = rs ? -s : s;
        if (m < 8) return {rs, 4'h0, m[2:0], 4'b0000};
        k = 0;
        while ((m >> k) >= 16) k++;
        q = m >> k;
        rem = m - (q << k);
        half = (k > 0) ? (1 << (k - 1)) : 0;
        up = (k > 0) && (rem > half || (rem == half && (q % 2) == 1));
        inx = (rem != 0);
        q = q + int'(up);
        if (q == 16) begin q = 8; k++; end
        e = k + 1;
        if (e >= 15) return {rs, 7'h78, 4'b0101};
        return {rs, e[3:0], q[2:0], 3'b000, inx};
    endfunction

    function automatic string tag_of(logic [7:0] a, logic [7:0] b, logic [11:0] ex);
        if (ex[11:4] == 8'h7C && ex[3]) return "R6";
        if (ex[11:4] == 8'h7C) return "R4";
        if (a[6:3] == 4'hF || b[6:3] == 4'hF) return "R5";
        if (ex[2]) return "R7";
        if (ex[10:4] == 7'h00) return "R8";
        if (ex[10:7] == 4'h0) return "R3";
        if (a[6:3] == 4'h0 || b[6:3] == 4'h0) return "R1";
        if (ex[0]) return "R11";
        return "R2";
    endfunction

    task automatic check_sp(string tag, logic [31:0] exp_res, logic [3:0] exp_fl);
        n_checks++;
        if (w_sum !== exp_res || {w_inv, w_ovf, w_unf, w_inx} !== exp_fl) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h sub=%0d got=%h/%b expected=%h/%b", tag,
                     w_a, w_b, w_sub, w_sum, {w_inv, w_ovf, w_unf, w_inx}, exp_res, exp_fl);
        end
    endtask

    // Called at a falling edge: drive, wait one cycle, compare.
    task automatic run_sp(string tag, logic [31:0] a, logic [31:0] b, logic sub,
                          logic [31:0] exp_res, logic [3:0] exp_fl);
        w_a = a; w_b = b; w_sub = sub;
        @(negedge clk);
        check_sp(tag, exp_res, exp_fl);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        s_a = '0; s_b = '0; s_sub = 1'b0;
        w_a = 32'h3F800000; w_b = 32'h3F800000; w_sub = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears all outputs.
        check_sp("R10", 32'h0, 4'b0000);
        n_checks++;
        if (s_sum !== 8'h00 || {s_inv, s_ovf, s_unf, s_inx} !== 4'b0000) begin
            n_errors++;
            $display("FAIL R10 small reset got=%h expected=00", s_sum);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_sp("R1", 32'h40000000, 4'b0000);

        // R10: a new operand does not reach the output before the next edge.
        w_a = 32'h40400000; w_b = 32'h3F800000; w_sub = 1'b1;
        #1;
        check_sp("R10", 32'h40000000, 4'b0000);
        @(negedge clk);
        check_sp("R9", 32'h40000000, 4'b0000);

        run_sp("R2",  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'b0001);
        run_sp("R2",  32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 4'b0001);
        run_sp("R11", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 4'b0001);
        run_sp("R11", 32'h3F800000, 32'h3F000000, 1'b0, 32'h3FC00000, 4'b0000);
        run_sp("R3",  32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 4'b0000);
        run_sp("R3",  32'h007FFFFF, 32'h00000001, 1'b0, 32'h00800000, 4'b0000);
        run_sp("R3",  32'h00800000, 32'h00000001, 1'b1, 32'h007FFFFF, 4'b0000);
        run_sp("R4",  32'hFFC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b0000);
        run_sp("R5",  32'h7F800000, 32'hBF800000, 1'b0, 32'h7F800000, 4'b0000);
        run_sp("R6",  32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 4'b1000);
        run_sp("R6",  32'hFF800000, 32'hFF800000, 1'b1, 32'h7FC00000, 4'b1000);
        run_sp("R7",  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'b0101);
        run_sp("R8",  32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'b0000);
        run_sp("R8",  32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 4'b0000);
        run_sp("R9",  32'h3F800000, 32'h40000000, 1'b1, 32'hBF800000, 4'b0000);

        // Exhaustive sweep of the small format, add and subtract.
        for (int sb = 0; sb < 2; sb++) begin
            for (int ia = 0; ia < 256; ia++) begin
                for (int ib = 0; ib < 256; ib++) begin
                    logic [11:0] ex;
                    s_a = 8'(ia); s_b = 8'(ib); s_sub = sb[0];
                    @(negedge clk);
                    ex = ref_small(8'(ia), 8'(ib), sb[0]);
                    n_checks++;
                    if ({s_sum, s_inv, s_ovf, s_unf, s_inx} !== ex) begin
                        n_errors++;
                        $display("FAIL %s%s a=%h b=%h sub=%0d got=%h/%b expected=%h/%b",
                                 tag_of(8'(ia), 8'(ib), ex), sb[0] ? " (R9)" : "",
                                 s_a, s_b, s_sub, s_sum, {s_inv, s_ovf, s_unf, s_inx},
                                 ex[11:4], ex[3:0]);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule